// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block cleans up an asynchronous, active-low external reset pin before the reset controller sees it. A synchronizer brings the pin into the bus clock domain first. A qualifier then changes the filtered level only after enough consecutive samples in a row show the new level. A sample that shows the old level resets the count to zero, so a glitch shorter than the qualifying count never reaches the output.

Two filter sources are available. The bus-clock filter takes one sample every clock, and its count can be set from 1 to 32. The low-power filter takes one sample each time a slow-oscillator tick arrives and needs a fixed 3 samples. Two small byte registers hold the configuration. One setting applies in run/wait, a second applies while the `stop_mode` input is high, and either setting may also bypass filtering. Whenever the mode in effect changes, the qualifier restarts, so a partial count never carries from one mode into the next.

The qualifier is a two-state machine. In `QS_HOLD`, the synchronized level agrees with the output and nothing is pending. In `QS_QUAL`, a new level is being counted.

Transitions:
- **HOLD→QUAL**: a sample disagrees with the output and the count needed is above 1.
- **HOLD→HOLD with flip**: a sample disagrees and the count needed is exactly 1.
- **QUAL→QUAL**: the count grows and stays below the count needed.
- **QUAL→HOLD with flip**: the count is reached.
- **QUAL→HOLD with reload**: a sample agrees with the output again.
- **any→HOLD (restart)**: the mode in effect differs from the mode seen on the last edge.

Top module: `rstpin_filter`

## Requirements
- R1: After reset, both configuration registers read 0x00, filtering is bypassed, and `filt_pin_n` is 1.
- R2: Registers are decoded at two byte addresses.
  - Address 0x4 is the mode register. Bits [1:0] select the run/wait mode, bit 2 selects the stop mode, and bits [7:3] read 0.
  - Address 0x5 is the width register. Bits [4:0] hold the width, and bits [7:5] read 0.
  - Writes to any other address change nothing, and reads from any other address return 0x00.
- R3: With filtering bypassed (run/wait select 00), a pin change shows on `filt_pin_n` at the third rising clock edge after the change is applied.
- R4: With run/wait select 01, a pin change shows on `filt_pin_n` at rising edge 2+(W+1) after the change, where W is the width field. The output is unchanged one edge earlier.
- R5: In bus-clock mode, a pin pulse that lasts W clock cycles (one sample short of W+1) leaves `filt_pin_n` unchanged.
- R6: With run/wait select 10, only edges where `lp_tick` is 1 take a sample. The output flips at the third consecutive such sample of the new level. An old-level sample resets the count, and edges without a tick change nothing.
- R7: Run/wait select 11 behaves exactly like 00.
- R8: While `stop_mode` is 1, the run/wait select and the width are ignored. Stop bit 0 bypasses filtering, and stop bit 1 applies the 3-tick low-power filter.
- R9: On the first edge where the mode in effect differs from the previous edge, `filt_pin_n` holds and the count clears. Qualification then needs the full count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| pin_n | input | 1 | Raw asynchronous active-low reset pin |
| stop_mode | input | 1 | High while the system is in stop; selects the stop configuration |
| lp_tick | input | 1 | One-cycle strobe marking a low-power-oscillator sample point |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| filt_pin_n | output | 1 | Filtered pin level, active low |

## Verification
Each pin change takes two synchronizer edges. After that, the output flips on the edge that takes the last qualifying sample. That is edge 3 when filtering is bypassed, edge 2+W+1 for the bus filter, and the edge of the third low-power tick that counts from edge 3 onward. The bench applies every stimulus at a falling edge and counts rising edges from that point. It samples one edge before the predicted flip and at the flip, sweeping all 32 widths and four tick periods. Register reads are checked combinationally, one nanosecond after the address settles. Mode-change tests sample at each of the two restart edges and again at the edge where a carried-over count would have flipped early.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    typedef enum logic [1:0] {
        FM_OFF = 2'd0,
        FM_BUS = 2'd1,
        FM_LP  = 2'd2
    } fmode_e;

    typedef enum logic {
        QS_HOLD = 1'b0,
        QS_QUAL = 1'b1
    } qstate_e;

endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rpf_regs.sv
module rpf_regs #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WSEL_W   = 5,
    parameter int CTRL_OFS = 4,
    parameter int WID_OFS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        run_sel,
    output logic              stop_sel,
    output logic [WSEL_W-1:0] width
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] WID_A  = ADDR_W'(WID_OFS);

    logic [1:0]        run_sel_q;
    logic              stop_sel_q;
    logic [WSEL_W-1:0] width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_sel_q  <= 2'b00;
            stop_sel_q <= 1'b0;
            width_q    <= '0;
        end else if (we) begin
            if (addr == CTRL_A) begin
                run_sel_q  <= wdata[1:0];
                stop_sel_q <= wdata[2];
            end
            if (addr == WID_A) begin
                width_q <= wdata[WSEL_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_A) begin
            rdata[2:0] = {stop_sel_q, run_sel_q};
        end else if (addr == WID_A) begin
            rdata[WSEL_W-1:0] = width_q;
        end
    end

    assign run_sel  = run_sel_q;
    assign stop_sel = stop_sel_q;
    assign width    = width_q;
endmodule

// File: rtl/rpf_qual.sv
module rpf_qual
    import rpf_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int LP_NEED = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fmode_e           mode,
    input  logic [CNT_W-1:0] bus_need,
    input  logic             samp,
    input  logic             lp_tick,
    output logic             filt,
    output fmode_e           mode_seen,
    output logic [CNT_W-1:0] cnt_seen
);
    localparam logic [CNT_W-1:0] LP_N = CNT_W'(LP_NEED);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    qstate_e          st_q, st_d;
    fmode_e           mode_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic [CNT_W-1:0] need;
    logic             take;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= QS_HOLD;
            mode_q <= FM_OFF;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            st_q   <= st_d;
            mode_q <= mode;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    // next state and output level
    always_comb begin
        need  = (mode == FM_LP) ? LP_N : bus_need;
        take  = (mode == FM_BUS) || ((mode == FM_LP) && lp_tick);
        st_d  = st_q;
        cnt_d = cnt_q;
        out_d = out_q;
        if (mode != mode_q) begin
            st_d  = QS_HOLD;
            cnt_d = '0;
        end else if (mode == FM_OFF) begin
            st_d  = QS_HOLD;
            cnt_d = '0;
            out_d = samp;
        end else if (take) begin
            unique case (st_q)
                QS_HOLD: begin
                    if (samp != out_q) begin
                        if (need <= ONE) begin
                            out_d = samp;
                        end else begin
                            st_d  = QS_QUAL;
                            cnt_d = ONE;
                        end
                    end
                end
                QS_QUAL: begin
                    if (samp == out_q) begin
                        st_d  = QS_HOLD;
                        cnt_d = '0;
                    end else if ((cnt_q + ONE) >= need) begin
                        st_d  = QS_HOLD;
                        cnt_d = '0;
                        out_d = samp;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                default: begin
                    st_d  = QS_HOLD;
                    cnt_d = '0;
                end
            endcase
        end
    end

    assign filt      = out_q;
    assign mode_seen = mode_q;
    assign cnt_seen  = cnt_q;
endmodule

// File: rtl/rstpin_filter.sv
module rstpin_filter
    import rpf_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int WSEL_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int LP_NEED     = 3,
    parameter int CTRL_OFS    = 4,
    parameter int WID_OFS     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_n,
    input  logic              stop_mode,
    input  logic              lp_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              filt_pin_n
);
    localparam int CNT_W = WSEL_W + 1;

    logic [1:0]        run_sel;
    logic              stop_sel;
    logic [WSEL_W-1:0] width;
    logic              sync_lvl;
    fmode_e            eff_mode;
    fmode_e            qual_mode;
    logic [CNT_W-1:0]  qual_cnt;
    logic [CNT_W-1:0]  bus_need;

    rpf_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (8),
        .WSEL_W  (WSEL_W),
        .CTRL_OFS(CTRL_OFS),
        .WID_OFS (WID_OFS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .run_sel (run_sel),
        .stop_sel(stop_sel),
        .width   (width)
    );

    rpf_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pin_n),
        .q      (sync_lvl)
    );

    always_comb begin
        if (stop_mode) begin
            eff_mode = stop_sel ? FM_LP : FM_OFF;
        end else begin
            case (run_sel)
                2'b01:   eff_mode = FM_BUS;
                2'b10:   eff_mode = FM_LP;
                default: eff_mode = FM_OFF;
            endcase
        end
    end

    assign bus_need = CNT_W'(width) + CNT_W'(1);

    rpf_qual #(
        .CNT_W  (CNT_W),
        .LP_NEED(LP_NEED)
    ) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (eff_mode),
        .bus_need (bus_need),
        .samp     (sync_lvl),
        .lp_tick  (lp_tick),
        .filt     (filt_pin_n),
        .mode_seen(qual_mode),
        .cnt_seen (qual_cnt)
    );
endmodule

// File: rtl/rpf_chk.sv
module rpf_chk
    import rpf_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int WSEL_W   = 5,
    parameter int CNT_W    = 6,
    parameter int LP_NEED  = 3,
    parameter int CTRL_OFS = 4,
    parameter int WID_OFS  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              lp_tick,
    input fmode_e            eff_mode,
    input fmode_e            qual_mode,
    input logic [CNT_W-1:0]  qual_cnt,
    input logic              sync_lvl,
    input logic              filt_pin_n
);
    // R2
    ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(CTRL_OFS)) |-> (reg_rdata[7:3] == 5'd0));

    // R2
    wid_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(WID_OFS)) |-> (reg_rdata[7:WSEL_W] == '0));

    // R3
    flip_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_pin_n != $past(filt_pin_n)) |-> (filt_pin_n == $past(sync_lvl)));

    // R9
    mode_restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode != qual_mode) |=> $stable(filt_pin_n));

    // R6
    lp_no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((eff_mode == FM_LP) && (qual_mode == FM_LP) && !lp_tick) |=> $stable(filt_pin_n));

    // R6
    lp_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_mode == FM_LP) |-> (qual_cnt < CNT_W'(LP_NEED)));
endmodule

bind rstpin_filter rpf_chk #(
    .ADDR_W  (ADDR_W),
    .WSEL_W  (WSEL_W),
    .CNT_W   (CNT_W),
    .LP_NEED (LP_NEED),
    .CTRL_OFS(CTRL_OFS),
    .WID_OFS (WID_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lp_tick   (lp_tick),
    .eff_mode  (eff_mode),
    .qual_mode (qual_mode),
    .qual_cnt  (qual_cnt),
    .sync_lvl  (sync_lvl),
    .filt_pin_n(filt_pin_n)
);

// File: tb/rstpin_filter_tb.sv
module rstpin_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_n = 1'b1;
    logic       stop_mode = 1'b0;
    logic       lp_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       filt_pin_n;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rstpin_filter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (pin_n),
        .stop_mode (stop_mode),
        .lp_tick   (lp_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .filt_pin_n(filt_pin_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic out_chk(input string tag, input logic exp);
        chk(tag, {7'd0, filt_pin_n}, {7'd0, exp});
    endtask

    task automatic quiet();
        stop_mode = 1'b0;
        lp_tick   = 1'b0;
        wr(4'h4, 8'h00);
        pin_n = 1'b1;
        adv(5);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        adv(3);
        rst_n = 1'b1;
        adv(1);

        // R1 reset state
        out_chk("R1 output after reset", 1'b1);
        rd_chk("R1 mode reg reset", 4'h4, 8'h00);
        rd_chk("R1 width reg reset", 4'h5, 8'h00);

        // R2 decode, reserved bits, foreign addresses
        wr(4'h6, 8'hFF);
        wr(4'h7, 8'hFF);
        wr(4'h3, 8'hFF);
        rd_chk("R2 mode reg untouched by other addr", 4'h4, 8'h00);
        rd_chk("R2 width reg untouched by other addr", 4'h5, 8'h00);
        rd_chk("R2 other addr reads zero", 4'h6, 8'h00);
        wr(4'h4, 8'hFF);
        rd_chk("R2 mode reg masks", 4'h4, 8'h07);
        wr(4'h5, 8'hFF);
        rd_chk("R2 width reg masks", 4'h5, 8'h1F);
        wr(4'h5, 8'h00);
        quiet();

        // R3 bypass latency
        pin_n = 1'b0; adv(2); out_chk("R3 bypass before", 1'b1);
        adv(1); out_chk("R3 bypass flip low", 1'b0);
        pin_n = 1'b1; adv(2); out_chk("R3 bypass before rise", 1'b0);
        adv(1); out_chk("R3 bypass flip high", 1'b1);

        // R7 select 11 acts as bypass
        wr(4'h5, 8'h1F);
        wr(4'h4, 8'h03);
        adv(3);
        pin_n = 1'b0; adv(2); out_chk("R7 reserved before", 1'b1);
        adv(1); out_chk("R7 reserved flip", 1'b0);
        pin_n = 1'b1; adv(3); out_chk("R7 reserved rise", 1'b1);
        quiet();

        // R4 / R5 sweep over every width
        for (int w = 0; w < 32; w++) begin
            int need;
            need = w + 1;
            quiet();
            wr(4'h5, 8'(w));
            wr(4'h4, 8'h01);
            adv(3);
            pin_n = 1'b0; adv(1 + need); out_chk("R4 fall held", 1'b1);
            adv(1); out_chk("R4 fall flip", 1'b0);
            pin_n = 1'b1; adv(1 + need); out_chk("R4 rise held", 1'b0);
            adv(1); out_chk("R4 rise flip", 1'b1);
            if (w >= 1) begin
                pin_n = 1'b0; adv(w);
                pin_n = 1'b1; adv(need + 4);
                out_chk("R5 short pulse rejected", 1'b1);
            end
        end

        // R6 low-power filter over tick periods 1..4
        for (int p = 1; p <= 4; p++) begin
            int seen;
            seen = 0;
            quiet();
            wr(4'h4, 8'h02);
            adv(3);
            pin_n = 1'b0;
            for (int i = 1; i <= 20; i++) begin
                lp_tick = ((i % p) == 0);
                @(posedge clk);
                @(negedge clk);
                if (i >= 3 && (i % p) == 0) seen++;
                out_chk("R6 tick qualification", (seen >= 3) ? 1'b0 : 1'b1);
            end
            lp_tick = 1'b0;
        end

        // R6 reload on a short low-power pulse
        quiet();
        wr(4'h4, 8'h02);
        adv(3);
        lp_tick = 1'b1;
        pin_n = 1'b0; adv(2);
        pin_n = 1'b1; adv(10);
        out_chk("R6 short pulse rejected", 1'b1);
        lp_tick = 1'b0;

        // R8 stop configuration overrides run/wait
        quiet();
        wr(4'h5, 8'h1F);
        wr(4'h4, 8'h01);
        stop_mode = 1'b1;
        adv(3);
        pin_n = 1'b0; adv(2); out_chk("R8 stop bypass before", 1'b1);
        adv(1); out_chk("R8 stop bypass flip", 1'b0);
        pin_n = 1'b1; adv(3); out_chk("R8 stop bypass rise", 1'b1);
        wr(4'h4, 8'h05);
        adv(3);
        lp_tick = 1'b1;
        pin_n = 1'b0; adv(4); out_chk("R8 stop lp before", 1'b1);
        adv(1); out_chk("R8 stop lp flip", 1'b0);
        lp_tick = 1'b0;
        pin_n = 1'b1;
        quiet();

        // R9 mode change restarts the count
        wr(4'h5, 8'h07);
        wr(4'h4, 8'h01);
        adv(3);
        pin_n = 1'b0; adv(6);
        stop_mode = 1'b1; adv(1); out_chk("R9 hold entering stop", 1'b1);
        stop_mode = 1'b0; adv(1); out_chk("R9 hold leaving stop", 1'b1);
        adv(7); out_chk("R9 no carried count", 1'b1);
        adv(1); out_chk("R9 full recount flip", 1'b0);
        quiet();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule